// File: doc/BRIEF.md
# Panel Self-Refresh Sequencer

This block steps a display source through the self-refresh life cycle of a panel that keeps its own copy of the frame. It advances one state at a time. Software owns some of the steps: it turns the feature on, asks for entry and, in manual mode, asks for exit. The block owns the rest: it sends the static frame, parks the link, sends the one-frame refresh and returns after the sink acknowledges the wake message. It works frame by frame from a frame-start strobe and a frame-changed flag sampled with that strobe.

In automatic mode the block enters self-refresh by itself. It does so after a run of unchanged frames whose length is programmable, with a floor of six. It leaves self-refresh when a changed frame arrives. In both modes a sleep timer measured in frames can force an exit, and a one-shot request can push a single new frame into the panel buffer without leaving self-refresh. The block reports the state number and a transition flag. It raises one-cycle pulses that tell the link logic to send the static frame, to power down, or to send a wake message (a write of 01h to the sink's power-state register).

Top module: `psr_seq`

## Requirements
- R1: After reset `stateOut` is 0, and `inTrans`, `sfuPending`, `sendStatic`, `linkDown` and `wakeReq` are all 0. The state codes are 0 off, 1 inactive, 2 static-frame entry, 3 active with no buffer update, 4 active with a one-frame update, and 5 exit.
- R2: In state 0 with `ctlEnable` high, the state becomes 1 at the next clock. With `autoMode` low and `ctlEntry` low it then stays at 1.
- R3: In state 1 with `autoMode` low and `ctlEntry` high, the state becomes 2 at the next clock, and `sendStatic` is high for that one cycle. From state 2 the next `frameStart` moves the state to 3, and `linkDown` is high for one cycle.
- R4: In state 3 with `autoMode` low, dropping `ctlEntry` moves the state to 5 at the next clock without passing through 4, and `wakeReq` is high for one cycle. State 5 holds until `wakeAck` is high, then the state becomes 1.
- R5: In state 1 with `autoMode` high, each `frameStart` with `frameDirty` low counts one clean frame, and a `frameStart` with `frameDirty` high resets the count. When the count reaches max(`idleCfg`, 6), the state becomes 2 at the following clock. `ctlEntry` is ignored in this mode.
- R6: In state 3 with `autoMode` high, a `frameStart` with `frameDirty` high moves the state to 5. `ctlEntry` low and clean frames leave the state at 3.
- R7: With `sleepCfg` nonzero, the `sleepCfg`-th `frameStart` seen in state 3 moves the state to 5 at the following clock. A `sleepCfg` of 0 turns the timer off.
- R8: A `sfuSet` pulse while enabled and out of state 0 sets `sfuPending`. In state 3 the next `frameStart` with the flag set moves the state to 4. The following `frameStart` returns the state to 3 and clears the flag. A `sfuSet` in state 0 is ignored.
- R9: `ctlEnable` low sends any state to 0 at the next clock and clears `sfuPending`.
- R10: `inTrans` is high exactly in states 2 and 5. No more than one of the three request pulses is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | One-cycle strobe at the start of each frame |
| frameDirty | input | 1 | Frame content changed; sampled with frameStart |
| ctlEnable | input | 1 | Software enable |
| ctlEntry | input | 1 | Software request to enter or stay in self-refresh (manual mode) |
| autoMode | input | 1 | 1 selects entry and exit by frame activity |
| sfuSet | input | 1 | Pulse requesting one frame update to the panel buffer |
| idleCfg | input | 4 | Clean frames needed before automatic entry (floor 6) |
| sleepCfg | input | 5 | Maximum frames in state 3; 0 disables |
| wakeAck | input | 1 | Sink acknowledged the wake message |
| stateOut | output | 3 | Current state number |
| inTrans | output | 1 | High in states 2 and 5 |
| sfuPending | output | 1 | One-frame update requested and not yet done |
| sendStatic | output | 1 | Pulse: send static frame |
| linkDown | output | 1 | Pulse: power the link down |
| wakeReq | output | 1 | Pulse: send wake message |

## Verification
The idle threshold is swept over every `idleCfg` value. Each run checks that one frame short of max(`idleCfg`, 6) clean frames leaves the block inactive and that a dirty frame in the middle restarts the run, which separates the floor from the raw setting. The sleep timer is swept over several lengths and over zero, which shows whether the limit is off by one and whether zero disables it. Manual and automatic exits are both driven, each together with the opposite mode's trigger, to show that the trigger of the inactive mode is ignored. The one-frame update is driven through its full 3→4→3 round trip and is also requested while off, where it must have no effect.

// File: rtl/psr_pkg.sv
package psr_pkg;
  typedef enum logic [2:0] {
    ST_OFF      = 3'd0,
    ST_IDLE     = 3'd1,
    ST_STATIC   = 3'd2,
    ST_SLEEP    = 3'd3,
    ST_ONEFRAME = 3'd4,
    ST_EXIT     = 3'd5
  } psrState_e;

  // strobes from the control FSM to the counter datapath
  typedef struct packed {
    logic clrIdle;
    logic incIdle;
    logic clrSleep;
    logic incSleep;
  } dpCmd_t;
endpackage

// File: rtl/psr_dp.sv
module psr_dp
  import psr_pkg::*;
#(
  parameter int IDLE_W   = 4,
  parameter int SLEEP_W  = 5,
  parameter int MIN_IDLE = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCmd_t             cmd,
  input  logic [IDLE_W-1:0]  idleCfg,
  input  logic [SLEEP_W-1:0] sleepCfg,
  output logic               idleHit,
  output logic               sleepHit
);
  localparam logic [IDLE_W-1:0] IDLE_FLOOR = IDLE_W'(MIN_IDLE);
  localparam logic [IDLE_W-1:0] IDLE_SAT   = {IDLE_W{1'b1}};

  logic [IDLE_W-1:0]  idleCnt;
  logic [SLEEP_W-1:0] sleepCnt;
  logic [IDLE_W-1:0]  effIdle;

  assign effIdle = (idleCfg < IDLE_FLOOR) ? IDLE_FLOOR : idleCfg;

  // clean-frame run length, saturating
  always_ff @(posedge clk) begin
    if (!rstN || cmd.clrIdle) idleCnt <= '0;
    else if (cmd.incIdle && idleCnt != IDLE_SAT) idleCnt <= idleCnt + 1'b1;
  end

  // frames spent in the active state
  always_ff @(posedge clk) begin
    if (!rstN || cmd.clrSleep) sleepCnt <= '0;
    else if (cmd.incSleep) sleepCnt <= sleepCnt + 1'b1;
  end

  assign idleHit  = (idleCnt >= effIdle);
  assign sleepHit = (sleepCfg != '0) && (sleepCnt == sleepCfg);
endmodule

// File: rtl/psr_ctrl.sv
module psr_ctrl
  import psr_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      frameStart,
  input  logic      frameDirty,
  input  logic      ctlEnable,
  input  logic      ctlEntry,
  input  logic      autoMode,
  input  logic      sfuSet,
  input  logic      wakeAck,
  input  logic      idleHit,
  input  logic      sleepHit,
  output dpCmd_t    cmd,
  output psrState_e curState,
  output logic      inTrans,
  output logic      sfuPending,
  output logic      sendStatic,
  output logic      linkDown,
  output logic      wakeReq
);
  psrState_e nxtState;
  logic      entryReq;
  logic      exitReq;
  logic      sfuDone;

  assign entryReq = autoMode ? idleHit : ctlEntry;
  assign exitReq  = (autoMode ? (frameStart && frameDirty) : !ctlEntry) || sleepHit;

  always_comb begin
    nxtState = curState;
    if (!ctlEnable) nxtState = ST_OFF;
    else begin
      unique case (curState)
        ST_OFF:      nxtState = ST_IDLE;
        ST_IDLE:     if (entryReq) nxtState = ST_STATIC;
        ST_STATIC:   if (frameStart) nxtState = ST_SLEEP;
        ST_SLEEP: begin
          if (exitReq) nxtState = ST_EXIT;
          else if (frameStart && sfuPending) nxtState = ST_ONEFRAME;
        end
        ST_ONEFRAME: if (frameStart) nxtState = ST_SLEEP;
        ST_EXIT:     if (wakeAck) nxtState = ST_IDLE;
        default:     nxtState = ST_OFF;
      endcase
    end
  end

  assign sfuDone = (curState == ST_ONEFRAME) && (nxtState == ST_SLEEP);

  always_comb begin
    cmd.clrIdle  = (curState != ST_IDLE) || (frameStart && frameDirty);
    cmd.incIdle  = (curState == ST_IDLE) && frameStart && !frameDirty;
    cmd.clrSleep = (curState != ST_SLEEP);
    cmd.incSleep = (curState == ST_SLEEP) && frameStart;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curState   <= ST_OFF;
      inTrans    <= 1'b0;
      sendStatic <= 1'b0;
      linkDown   <= 1'b0;
      wakeReq    <= 1'b0;
    end else begin
      curState   <= nxtState;
      inTrans    <= (nxtState == ST_STATIC) || (nxtState == ST_EXIT);
      sendStatic <= (nxtState == ST_STATIC) && (curState != ST_STATIC);
      linkDown   <= (nxtState == ST_SLEEP)  && (curState != ST_SLEEP);
      wakeReq    <= (nxtState == ST_EXIT)   && (curState != ST_EXIT);
    end
  end

  // one-shot update flag: a new request wins over completion
  always_ff @(posedge clk) begin
    if (!rstN || !ctlEnable || curState == ST_OFF) sfuPending <= 1'b0;
    else if (sfuSet) sfuPending <= 1'b1;
    else if (sfuDone) sfuPending <= 1'b0;
  end
endmodule

// File: rtl/psr_seq.sv
module psr_seq
  import psr_pkg::*;
#(
  parameter int IDLE_W   = 4,
  parameter int SLEEP_W  = 5,
  parameter int MIN_IDLE = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               frameStart,
  input  logic               frameDirty,
  input  logic               ctlEnable,
  input  logic               ctlEntry,
  input  logic               autoMode,
  input  logic               sfuSet,
  input  logic [IDLE_W-1:0]  idleCfg,
  input  logic [SLEEP_W-1:0] sleepCfg,
  input  logic               wakeAck,
  output logic [2:0]         stateOut,
  output logic               inTrans,
  output logic               sfuPending,
  output logic               sendStatic,
  output logic               linkDown,
  output logic               wakeReq
);
  dpCmd_t    cmd;
  psrState_e curState;
  logic      idleHit;
  logic      sleepHit;

  psr_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .frameDirty(frameDirty),
    .ctlEnable(ctlEnable), .ctlEntry(ctlEntry), .autoMode(autoMode),
    .sfuSet(sfuSet), .wakeAck(wakeAck), .idleHit(idleHit), .sleepHit(sleepHit),
    .cmd(cmd), .curState(curState), .inTrans(inTrans), .sfuPending(sfuPending),
    .sendStatic(sendStatic), .linkDown(linkDown), .wakeReq(wakeReq)
  );

  psr_dp #(.IDLE_W(IDLE_W), .SLEEP_W(SLEEP_W), .MIN_IDLE(MIN_IDLE)) dp_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .idleCfg(idleCfg), .sleepCfg(sleepCfg),
    .idleHit(idleHit), .sleepHit(sleepHit)
  );

  assign stateOut = curState;
endmodule

// File: rtl/psr_seq_chk.sv
module psr_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       ctlEnable,
  input logic       sfuSet,
  input logic       wakeAck,
  input logic [2:0] stateOut,
  input logic       inTrans,
  input logic       sfuPending,
  input logic       sendStatic,
  input logic       linkDown,
  input logic       wakeReq
);
  a_r9_disable_to_off: assert property (@(posedge clk) disable iff (!rstN)
    !ctlEnable |=> stateOut == 3'd0);

  a_r2_off_leads_to_idle: assert property (@(posedge clk) disable iff (!rstN)
    stateOut == 3'd0 |=> stateOut <= 3'd1);

  a_r4_exit_waits_ack: assert property (@(posedge clk) disable iff (!rstN)
    (stateOut == 3'd5 && !wakeAck && ctlEnable) |=> stateOut == 3'd5);

  a_r4_active_never_back_to_entry: assert property (@(posedge clk) disable iff (!rstN)
    stateOut == 3'd3 |=> (stateOut != 3'd1 && stateOut != 3'd2));

  a_r3_static_from_idle: assert property (@(posedge clk) disable iff (!rstN)
    sendStatic |-> (stateOut == 3'd2 && $past(stateOut) == 3'd1));

  a_r8_sfu_clears: assert property (@(posedge clk) disable iff (!rstN)
    (stateOut == 3'd3 && $past(stateOut) == 3'd4 && !$past(sfuSet)) |-> !sfuPending);

  a_r10_one_pulse: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({sendStatic, linkDown, wakeReq}));

  a_r10_trans_states: assert property (@(posedge clk) disable iff (!rstN)
    inTrans |-> (stateOut == 3'd2 || stateOut == 3'd5));
endmodule

bind psr_seq psr_seq_chk chk_i (
  .clk(clk), .rstN(rstN), .ctlEnable(ctlEnable), .sfuSet(sfuSet),
  .wakeAck(wakeAck), .stateOut(stateOut), .inTrans(inTrans),
  .sfuPending(sfuPending), .sendStatic(sendStatic), .linkDown(linkDown),
  .wakeReq(wakeReq)
);

// File: tb/psr_seq_tb.sv
module psr_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN;
  logic       frameStart, frameDirty, ctlEnable, ctlEntry, autoMode, sfuSet, wakeAck;
  logic [3:0] idleCfg;
  logic [4:0] sleepCfg;
  logic [2:0] stateOut;
  logic       inTrans, sfuPending, sendStatic, linkDown, wakeReq;

  int nChecks = 0;
  int nFail   = 0;
  int cycles  = 0;
  bit done    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  psr_seq dut_i (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .frameDirty(frameDirty),
    .ctlEnable(ctlEnable), .ctlEntry(ctlEntry), .autoMode(autoMode),
    .sfuSet(sfuSet), .idleCfg(idleCfg), .sleepCfg(sleepCfg), .wakeAck(wakeAck),
    .stateOut(stateOut), .inTrans(inTrans), .sfuPending(sfuPending),
    .sendStatic(sendStatic), .linkDown(linkDown), .wakeReq(wakeReq)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // frame strobe seen at one edge, then one quiet cycle
  task automatic frame(input logic dirty);
    frameStart = 1'b1; frameDirty = dirty;
    step();
    frameStart = 1'b0; frameDirty = 1'b0;
    step();
  endtask

  task automatic restart();
    ctlEnable = 1'b0; step();
    ctlEnable = 1'b1; step();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; frameStart = 0; frameDirty = 0; ctlEnable = 0; ctlEntry = 0;
    autoMode = 0; sfuSet = 0; wakeAck = 0; idleCfg = 4'd0; sleepCfg = 5'd0;
    repeat (3) step();
    rstN = 1'b1; step();

    // R1 reset values
    check("R1 state", stateOut, 0);
    check("R1 flags", {inTrans, sfuPending, sendStatic, linkDown, wakeReq}, 0);

    // R8 request while off is ignored
    sfuSet = 1'b1; step(); sfuSet = 1'b0; step();
    check("R8 sfu ignored when off", sfuPending, 0);

    // R2 enable
    ctlEnable = 1'b1; step();
    check("R2 enable to 1", stateOut, 1);
    repeat (4) frame(1'b0);
    check("R2 stays inactive", stateOut, 1);

    // R3 manual entry
    ctlEntry = 1'b1; step();
    check("R3 state 2", stateOut, 2);
    check("R3 sendStatic pulse", sendStatic, 1);
    check("R10 inTrans in 2", inTrans, 1);
    step();
    check("R3 waits frame", stateOut, 2);
    check("R3 pulse one cycle", sendStatic, 0);
    frameStart = 1'b1; step(); frameStart = 1'b0;
    check("R3 state 3", stateOut, 3);
    check("R3 linkDown pulse", linkDown, 1);
    check("R10 inTrans in 3", inTrans, 0);
    step();

    // R8 one-frame update round trip
    sfuSet = 1'b1; step(); sfuSet = 1'b0;
    check("R8 pending set", sfuPending, 1);
    frameStart = 1'b1; step(); frameStart = 1'b0;
    check("R8 state 4", stateOut, 4);
    check("R10 inTrans in 4", inTrans, 0);
    step();
    frameStart = 1'b1; step(); frameStart = 1'b0;
    check("R8 back to 3", stateOut, 3);
    check("R8 pending cleared", sfuPending, 0);
    step();

    // R4 manual exit, dirty frame ignored in manual mode
    frame(1'b1);
    check("R6 dirty ignored in manual", stateOut, 3);
    ctlEntry = 1'b0; step();
    check("R4 state 5", stateOut, 5);
    check("R4 wakeReq pulse", wakeReq, 1);
    check("R10 inTrans in 5", inTrans, 1);
    repeat (5) step();
    check("R4 holds for ack", stateOut, 5);
    wakeAck = 1'b1; step(); wakeAck = 1'b0;
    check("R4 ack to 1", stateOut, 1);

    // R9 disable from active with pending update
    ctlEntry = 1'b1; step(); frame(1'b0);
    sfuSet = 1'b1; step(); sfuSet = 1'b0;
    ctlEnable = 1'b0; step();
    check("R9 off", stateOut, 0);
    check("R9 pending cleared", sfuPending, 0);
    ctlEnable = 1'b1; ctlEntry = 1'b0; step();

    // R7 sleep timer sweep (manual mode)
    for (int s = 0; s <= 8; s++) begin
      sleepCfg = 5'(s);
      restart();
      ctlEntry = 1'b1; step(); frame(1'b0);
      if (s == 0) begin
        repeat (40) frame(1'b0);
        check("R7 zero disables timer", stateOut, 3);
      end else begin
        repeat (s - 1) frame(1'b0);
        check("R7 before limit", stateOut, 3);
        frame(1'b0);
        check("R7 at limit", stateOut, 5);
      end
      ctlEntry = 1'b0;
    end
    sleepCfg = 5'd0;

    // R5 automatic entry threshold sweep
    autoMode = 1'b1;
    for (int c = 0; c < 16; c++) begin
      int n;
      idleCfg = 4'(c);
      n = (c < 6) ? 6 : c;
      restart();
      ctlEntry = 1'b1;
      repeat (n - 1) frame(1'b0);
      check("R5 below threshold", stateOut, 1);
      frame(1'b1);
      repeat (n - 1) frame(1'b0);
      check("R5 dirty restarts count", stateOut, 1);
      frame(1'b0);
      check("R5 threshold reached", stateOut, 2);
    end

    // R6 automatic exit
    idleCfg = 4'd0;
    frame(1'b0);
    check("R6 active", stateOut, 3);
    ctlEntry = 1'b0; step(); frame(1'b0);
    check("R6 entry bit and clean frame ignored", stateOut, 3);
    frameStart = 1'b1; frameDirty = 1'b1; step(); frameStart = 1'b0; frameDirty = 1'b0;
    check("R6 dirty exits", stateOut, 5);
    check("R6 wakeReq", wakeReq, 1);
    wakeAck = 1'b1; step(); wakeAck = 1'b0;
    check("R6 back to 1", stateOut, 1);

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule